// File: doc/BRIEF.md
# Microwire Serial Word-Memory Slave

This block is the slave end of a four-wire Microwire link in front of a 256-word, 16-bit register-array memory. It holds a small write-protect unit beside the memory. The host selects the block by raising chip select. It then toggles the serial clock and presents bits on the data input. The block finds the start bit and collects the opcode, the address and, for the two write kinds, a data word. It decodes one of ten instructions using the opcode, the two address MSBs and the protect-select pin.

Reads return a leading zero and then the data, MSB first. A memory read keeps streaming consecutive words for as long as the host keeps clocking. Instructions that change state are held until the chip-select falling edge that ends the cycle. At that edge they are carried out only if the write-enable latch, the program-enable pin and the protect state all allow it. The serial pins are sampled by the block's own system clock, which must run well above the serial clock rate.

Top module: `mw_eeprom_slave`

## Requirements
- R1: While chip select is high and the block is idle, zeros on the data input are skipped. A cycle begins at the first serial-clock rise that samples a 1.
- R2: After the start bit the block takes 2 opcode bits, then 8 address bits, then 16 data bits for a memory write or write-all. Each field is sent MSB first and each bit is sampled on a serial-clock rise.
- R3: With protect-select low, the decode is: opcode 10 reads, 01 writes, and 00 with address MSBs 11 sets write-enable, 00 clears it, 01 writes all. Opcode 11 does nothing. Program-enable is ignored for the read and for the write-disable.
- R4: With protect-select high, the decode is: opcode 10 reads the protect value, 01 loads it, and 11 with address FF clears it to FF. Opcode 00 with address MSBs 11 arms the protect unit, and opcode 00 with address 00 locks it.
- R5: On a memory read, the serial-clock rise that samples the last address bit enables the output and drives a 0. Each later rise drives the next word bit, MSB first.
- R6: When clocking continues past a word, the next word follows at once with no extra zero. The address counts up and wraps from 255 to 0.
- R7: A protect read drives a 0, then the 8-bit protect value MSB first, then zeros.
- R8: The write-enable latch is cleared by reset. Set and clear take effect at the chip-select fall that ends their cycle. Set needs program-enable high. Reads work whichever state the latch is in.
- R9: The memory array is all zeros after reset. A word write lands at chip-select fall only if the latch is set, program-enable is high and the address is not protected. Otherwise the frame is consumed and nothing changes.
- R10: A write-all stores its word in every location, only when the protect value is FF, the latch is set and program-enable is high.
- R11: The protect value resets to FF. Addresses at or above it are protected, but FF protects nothing. Arming needs the latch set and program-enable high, and it lasts only to the next started cycle. Clear, load and lock need the arm and program-enable high. A load also needs the value to be FF.
- R12: After a lock, the protect value never changes again.
- R13: With chip select low, the output enable is low, serial clock and data are ignored, and the framing state returns to idle. A frame cut short does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Chip select, active high |
| sk_i | input | 1 | Serial clock from the host |
| di_i | input | 1 | Serial data from the host |
| pre_i | input | 1 | Protect-select: 1 targets the protect unit |
| pe_i | input | 1 | Program-enable: 1 allows state-changing instructions |
| do_o | output | 1 | Serial data to the host |
| do_oe_o | output | 1 | Output enable for the data pin (0 = high impedance) |

## Verification
The hardest situation to reach is the arm-consumption rule. A clear or load that follows an arm must fail as soon as any other cycle sits between them, even a harmless protect read. Reaching it takes a full sequence at the ports: set write-enable, arm, load a boundary, arm again, run a protect read, then try a clear. The test then reads the protect value back through another protect read. The lock test follows the same pattern: after the lock, a properly armed clear is sent and must leave the value unchanged.

// File: rtl/mw_pkg.sv
package mw_pkg;

   typedef enum logic [3:0] {
      INS_NONE,
      INS_READ,
      INS_WRITE,
      INS_WRALL,
      INS_WEN,
      INS_WDS,
      INS_PRREAD,
      INS_PRWRITE,
      INS_PRCLEAR,
      INS_PREN,
      INS_PRDS
   } mw_ins_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_OPC,
      ST_ADDR,
      ST_DATA,
      ST_RDOUT,
      ST_HOLD
   } mw_state_e;

   localparam logic [1:0] OPC_RD   = 2'b10;
   localparam logic [1:0] OPC_WR   = 2'b01;
   localparam logic [1:0] OPC_CTRL = 2'b00;
   localparam logic [1:0] OPC_CLR  = 2'b11;

endpackage

// File: rtl/mw_decode.sv
module mw_decode
   import mw_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              prot_sel,
   input  logic [1:0]        opc,
   input  logic [ADDR_W-1:0] addr,
   output mw_ins_e           ins
);

   logic [1:0] top2;
   assign top2 = addr[ADDR_W-1 -: 2];

   always_comb begin
      ins = INS_NONE;
      if (!prot_sel) begin
         case (opc)
            OPC_RD:   ins = INS_READ;
            OPC_WR:   ins = INS_WRITE;
            OPC_CTRL: begin
               case (top2)
                  2'b11:   ins = INS_WEN;
                  2'b00:   ins = INS_WDS;
                  2'b01:   ins = INS_WRALL;
                  default: ins = INS_NONE;
               endcase
            end
            default:  ins = INS_NONE;
         endcase
      end else begin
         case (opc)
            OPC_RD:   ins = INS_PRREAD;
            OPC_WR:   ins = INS_PRWRITE;
            OPC_CLR:  ins = (&addr) ? INS_PRCLEAR : INS_NONE;
            default: begin
               if (top2 == 2'b11)
                  ins = INS_PREN;
               else if (addr == '0)
                  ins = INS_PRDS;
               else
                  ins = INS_NONE;
            end
         endcase
      end
   end

endmodule

// File: rtl/mw_word_mem.sv
module mw_word_mem #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wrall_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] cells [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_cell
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cells[g] <= '0;
         else if (wrall_en || (wr_en && wr_addr == ADDR_W'(g)))
            cells[g] <= wr_data;
      end
   end

   assign rd_data = cells[rd_addr];

   // R9: a single strobe kind per cycle
   p_one_write_kind_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wr_en, wrall_en}));

endmodule

// File: rtl/mw_protect_unit.sv
module mw_protect_unit #(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_en,
   input  logic              set_en,
   input  logic [ADDR_W-1:0] set_val,
   input  logic              lock_en,
   input  logic [ADDR_W-1:0] chk_addr,
   output logic [ADDR_W-1:0] bound,
   output logic              is_clear,
   output logic              locked,
   output logic              blocked
);

   logic [ADDR_W-1:0] bound_q;
   logic              locked_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bound_q  <= '1;
         locked_q <= 1'b0;
      end else if (!locked_q) begin
         if (clr_en)
            bound_q <= '1;
         else if (set_en)
            bound_q <= set_val;
         if (lock_en)
            locked_q <= 1'b1;
      end
   end

   assign bound    = bound_q;
   assign locked   = locked_q;
   assign is_clear = &bound_q;
   assign blocked  = !is_clear && (chk_addr >= bound_q);

   p_lock_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
      locked_q |=> locked_q);

   p_bound_frozen_r12: assert property (@(posedge clk) disable iff (!rst_n)
      locked_q |=> $stable(bound_q));

endmodule

// File: rtl/mw_eeprom_slave.sv
module mw_eeprom_slave
   import mw_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 16,
   parameter bit SEQ_READ = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_i,
   input  logic sk_i,
   input  logic di_i,
   input  logic pre_i,
   input  logic pe_i,
   output logic do_o,
   output logic do_oe_o
);

   localparam int OPC_W = 2;
   localparam int MAXF  = (DATA_W > ADDR_W) ? DATA_W : ADDR_W;
   localparam int CNT_W = $clog2(MAXF) + 1;

   if (ADDR_W < 2) begin : g_bad_addr
      $error("ADDR_W must be at least 2");
   end
   if (DATA_W < ADDR_W) begin : g_bad_data
      $error("DATA_W must not be below ADDR_W");
   end

   // serial edge detection
   logic cs_q, sk_q, sk_rise, cs_fall;
   mw_state_e         state;
   logic [CNT_W-1:0]  cnt;
   logic [OPC_W-1:0]  opc_sh;
   logic [ADDR_W-1:0] addr_sh, addr_full, rd_ptr, mem_raddr;
   logic [DATA_W-1:0] data_sh, sreg, mem_rdata;
   mw_ins_e           ins_dec, ins_q;
   logic              pe_q, rd_mem, do_r, oe_r, reload_ok;
   logic              wen_q, armed_q;
   logic              ended, started;
   logic              mem_wr, mem_wrall, pr_clr, pr_set, pr_lock;
   logic [ADDR_W-1:0] pr_bound;
   logic              pr_is_clear, pr_locked, pr_blocked;

   assign sk_rise   = cs_i && sk_i && !sk_q;
   assign cs_fall   = cs_q && !cs_i;
   assign addr_full = {addr_sh[ADDR_W-2:0], di_i};
   assign mem_raddr = (state == ST_ADDR) ? addr_full : rd_ptr + 1'b1;

   if (SEQ_READ) begin : g_seq
      assign reload_ok = rd_mem;
   end else begin : g_single
      assign reload_ok = 1'b0;
   end

   mw_decode #(.ADDR_W(ADDR_W)) i_decode (
      .prot_sel (pre_i),
      .opc      (opc_sh),
      .addr     (addr_full),
      .ins      (ins_dec)
   );

   // framing and read sequencing
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q    <= 1'b0;
         sk_q    <= 1'b0;
         state   <= ST_IDLE;
         cnt     <= '0;
         opc_sh  <= '0;
         addr_sh <= '0;
         data_sh <= '0;
         sreg    <= '0;
         rd_ptr  <= '0;
         rd_mem  <= 1'b0;
         ins_q   <= INS_NONE;
         pe_q    <= 1'b0;
         do_r    <= 1'b0;
         oe_r    <= 1'b0;
      end else begin
         cs_q <= cs_i;
         sk_q <= sk_i;
         if (!cs_i) begin
            state <= ST_IDLE;
            cnt   <= '0;
            oe_r  <= 1'b0;
            do_r  <= 1'b0;
         end else if (sk_rise) begin
            case (state)
               ST_IDLE: begin
                  if (di_i) begin
                     state <= ST_OPC;
                     cnt   <= '0;
                  end
               end
               ST_OPC: begin
                  opc_sh <= {opc_sh[OPC_W-2:0], di_i};
                  if (cnt == CNT_W'(OPC_W - 1)) begin
                     state <= ST_ADDR;
                     cnt   <= '0;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_ADDR: begin
                  addr_sh <= addr_full;
                  if (cnt == CNT_W'(ADDR_W - 1)) begin
                     cnt   <= '0;
                     ins_q <= ins_dec;
                     pe_q  <= pe_i;
                     case (ins_dec)
                        INS_READ: begin
                           sreg   <= mem_rdata;
                           rd_ptr <= addr_full;
                           rd_mem <= 1'b1;
                           oe_r   <= 1'b1;
                           do_r   <= 1'b0;
                           state  <= ST_RDOUT;
                        end
                        INS_PRREAD: begin
                           sreg   <= DATA_W'(pr_bound) << (DATA_W - ADDR_W);
                           rd_mem <= 1'b0;
                           oe_r   <= 1'b1;
                           do_r   <= 1'b0;
                           state  <= ST_RDOUT;
                        end
                        INS_WRITE, INS_WRALL: state <= ST_DATA;
                        default:              state <= ST_HOLD;
                     endcase
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_DATA: begin
                  data_sh <= {data_sh[DATA_W-2:0], di_i};
                  if (cnt == CNT_W'(DATA_W - 1))
                     state <= ST_HOLD;
                  else
                     cnt <= cnt + 1'b1;
               end
               ST_RDOUT: begin
                  do_r <= sreg[DATA_W-1];
                  if (cnt == CNT_W'(DATA_W - 1) && reload_ok) begin
                     sreg   <= mem_rdata;
                     rd_ptr <= mem_raddr;
                     cnt    <= '0;
                  end else begin
                     sreg <= sreg << 1;
                     if (cnt != CNT_W'(DATA_W - 1))
                        cnt <= cnt + 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // execution at the end of a cycle
   assign ended   = cs_fall && (state == ST_HOLD || state == ST_RDOUT);
   assign started = cs_fall && (state != ST_IDLE);

   assign mem_wr    = ended && ins_q == INS_WRITE && wen_q && pe_q && !pr_blocked;
   assign mem_wrall = ended && ins_q == INS_WRALL && wen_q && pe_q && pr_is_clear;
   assign pr_clr    = ended && ins_q == INS_PRCLEAR && armed_q && pe_q && !pr_locked;
   assign pr_set    = ended && ins_q == INS_PRWRITE && armed_q && pe_q && !pr_locked
                      && pr_is_clear;
   assign pr_lock   = ended && ins_q == INS_PRDS && armed_q && pe_q && !pr_locked;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wen_q   <= 1'b0;
         armed_q <= 1'b0;
      end else begin
         if (ended && ins_q == INS_WEN && pe_q)
            wen_q <= 1'b1;
         else if (ended && ins_q == INS_WDS)
            wen_q <= 1'b0;
         if (started)
            armed_q <= ended && ins_q == INS_PREN && wen_q && pe_q;
      end
   end

   mw_word_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_mem (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (mem_wr),
      .wrall_en (mem_wrall),
      .wr_addr  (addr_sh),
      .wr_data  (data_sh),
      .rd_addr  (mem_raddr),
      .rd_data  (mem_rdata)
   );

   mw_protect_unit #(.ADDR_W(ADDR_W)) i_protect (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_en   (pr_clr),
      .set_en   (pr_set),
      .set_val  (addr_sh),
      .lock_en  (pr_lock),
      .chk_addr (addr_sh),
      .bound    (pr_bound),
      .is_clear (pr_is_clear),
      .locked   (pr_locked),
      .blocked  (pr_blocked)
   );

   assign do_o    = do_r;
   assign do_oe_o = oe_r;

   p_hiz_deselected_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_i |=> !do_oe_o);

   p_oe_after_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(do_oe_o) |-> $past(state == ST_ADDR));

   p_dummy_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(do_oe_o) |-> !do_o);

   p_wen_on_csfall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(wen_q) |-> $past(cs_fall));

   p_start_needs_one_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_OPC && $past(state) == ST_IDLE) |-> ($past(di_i) && $past(cs_i)));

endmodule

// File: tb/test_mw_eeprom_slave.sv
module test_mw_eeprom_slave;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs = 1'b0, sk = 1'b0, di = 1'b0, pre = 1'b0, pe = 1'b0;
   logic do_o, do_oe;
   int   n_chk = 0;
   int   n_fail = 0;
   bit   done = 1'b0;

   always #4 clk = ~clk;

   mw_eeprom_slave i_mw_eeprom_slave (
      .clk     (clk),
      .rst_n   (rst_n),
      .cs_i    (cs),
      .sk_i    (sk),
      .di_i    (di),
      .pre_i   (pre),
      .pe_i    (pe),
      .do_o    (do_o),
      .do_oe_o (do_oe)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic sk_bit(input logic d, output logic q);
      di = d;
      sk = 1'b0;
      repeat (2) @(negedge clk);
      sk = 1'b1;
      repeat (2) @(negedge clk);
      q = do_o;
   endtask

   task automatic hdr(input logic p_sel, input logic p_en, input logic [1:0] op,
                      input logic [7:0] a, input int zeros, output logic last_q);
      logic q;
      pre = p_sel;
      pe  = p_en;
      cs  = 1'b1;
      @(negedge clk);
      for (int i = 0; i < zeros; i++) sk_bit(1'b0, q);
      sk_bit(1'b1, q);
      for (int i = 1; i >= 0; i--) sk_bit(op[i], q);
      for (int i = 7; i >= 0; i--) sk_bit(a[i], q);
      last_q = q;
   endtask

   task automatic end_cs();
      sk = 1'b0;
      cs = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic cmd(input logic p_sel, input logic p_en, input logic [1:0] op,
                      input logic [7:0] a);
      logic q;
      hdr(p_sel, p_en, op, a, 0, q);
      end_cs();
   endtask

   task automatic send16(input logic [15:0] d);
      logic q;
      for (int i = 15; i >= 0; i--) sk_bit(d[i], q);
   endtask

   task automatic get16(output logic [15:0] w);
      logic q;
      for (int i = 15; i >= 0; i--) begin
         sk_bit(1'b0, q);
         w[i] = q;
      end
   endtask

   task automatic mem_write(input logic p_en, input logic [7:0] a, input logic [15:0] d);
      logic q;
      hdr(1'b0, p_en, 2'b01, a, 0, q);
      send16(d);
      end_cs();
   endtask

   task automatic mem_wrall(input logic p_en, input logic [15:0] d);
      logic q;
      hdr(1'b0, p_en, 2'b00, 8'h40, 0, q);
      send16(d);
      end_cs();
   endtask

   task automatic mem_read(input logic [7:0] a, output logic [15:0] w);
      logic q;
      hdr(1'b0, 1'b0, 2'b10, a, 0, q);
      get16(w);
      end_cs();
   endtask

   task automatic pr_read(output logic [7:0] v, output logic dummy, output logic [7:0] tail);
      logic q;
      hdr(1'b1, 1'b0, 2'b10, 8'h00, 0, q);
      dummy = q;
      for (int i = 7; i >= 0; i--) begin sk_bit(1'b0, q); v[i] = q; end
      for (int i = 7; i >= 0; i--) begin sk_bit(1'b0, q); tail[i] = q; end
      end_cs();
   endtask

   task automatic wen_cmd();  cmd(1'b0, 1'b1, 2'b00, 8'hC0); endtask
   task automatic pren_cmd(); cmd(1'b1, 1'b1, 2'b00, 8'hC0); endtask

   task automatic t_reset();
      logic [15:0] w;
      check("R13 oe low after reset", 32'(do_oe), 32'h0);
      mem_read(8'h03, w);
      check("R9 array zero after reset", 32'(w), 32'h0);
   endtask

   task automatic t_no_wen();
      logic [15:0] w;
      mem_write(1'b1, 8'h05, 16'h1111);
      mem_read(8'h05, w);
      check("R8 write ignored while latch clear", 32'(w), 32'h0);
   endtask

   task automatic t_enable_write();
      logic q;
      logic [15:0] w;
      hdr(1'b0, 1'b1, 2'b00, 8'hC0, 3, q);   // R1: leading zeros
      end_cs();
      mem_write(1'b1, 8'h05, 16'hA5C3);
      mem_write(1'b1, 8'hFF, 16'h1234);
      mem_write(1'b1, 8'h00, 16'hBEEF);
      hdr(1'b0, 1'b0, 2'b10, 8'h05, 0, q);
      check("R5 dummy bit is 0", 32'(q), 32'h0);
      check("R5 output enabled after last address bit", 32'(do_oe), 32'h1);
      get16(w);
      end_cs();
      check("R1 R2 R9 word written after WEN with leading zeros", 32'(w), 32'hA5C3);
      mem_read(8'hFF, w);
      check("R11 last address writable while bound is FF", 32'(w), 32'h1234);
   endtask

   task automatic t_sequential();
      logic q;
      logic [15:0] w;
      hdr(1'b0, 1'b0, 2'b10, 8'hFE, 0, q);
      get16(w); check("R6 word FE", 32'(w), 32'h0);
      get16(w); check("R6 word FF no extra zero", 32'(w), 32'h1234);
      get16(w); check("R6 wrap to word 00", 32'(w), 32'hBEEF);
      get16(w); check("R6 word 01", 32'(w), 32'h0);
      end_cs();
   endtask

   task automatic t_pe_low();
      logic [15:0] w;
      mem_write(1'b0, 8'h06, 16'h7777);
      mem_read(8'h06, w);
      check("R9 write with program-enable low ignored", 32'(w), 32'h0);
   endtask

   task automatic t_abort();
      logic q;
      logic [15:0] w;
      pre = 1'b0; pe = 1'b1; cs = 1'b1;
      @(negedge clk);
      sk_bit(1'b1, q); sk_bit(1'b0, q); sk_bit(1'b1, q);
      for (int i = 0; i < 5; i++) sk_bit(1'b1, q);
      end_cs();
      check("R13 oe low with chip select low", 32'(do_oe), 32'h0);
      for (int i = 0; i < 6; i++) sk_bit(1'b1, q);
      check("R13 clocking while deselected keeps oe low", 32'(do_oe), 32'h0);
      sk = 1'b0;
      mem_read(8'h07, w);
      check("R13 cut-short write does nothing", 32'(w), 32'h0);
      mem_read(8'h05, w);
      check("R13 fresh cycle framed after deselect", 32'(w), 32'hA5C3);
   endtask

   task automatic t_wds();
      logic [15:0] w;
      cmd(1'b0, 1'b0, 2'b00, 8'h00);         // WDS with program-enable low
      mem_write(1'b1, 8'h09, 16'h9999);
      mem_read(8'h09, w);
      check("R3 R8 write-disable taken with PE low", 32'(w), 32'h0);
      mem_read(8'h00, w);
      check("R8 read works with latch clear", 32'(w), 32'hBEEF);
   endtask

   task automatic t_prread_default();
      logic [7:0] v, tail;
      logic dmy;
      pr_read(v, dmy, tail);
      check("R7 protect read dummy 0", 32'(dmy), 32'h0);
      check("R7 R11 protect value resets to FF", 32'(v), 32'hFF);
      check("R7 zeros after protect value", 32'(tail), 32'h0);
   endtask

   task automatic t_pren_needs_wen();
      logic [7:0] v, tail;
      logic dmy;
      pren_cmd();
      cmd(1'b1, 1'b1, 2'b01, 8'h80);
      pr_read(v, dmy, tail);
      check("R11 arm refused without write-enable", 32'(v), 32'hFF);
   endtask

   task automatic t_protect_range();
      logic [7:0] v, tail;
      logic dmy;
      logic [15:0] w;
      wen_cmd();
      pren_cmd();
      cmd(1'b1, 1'b1, 2'b01, 8'h80);
      pr_read(v, dmy, tail);
      check("R4 protect load", 32'(v), 32'h80);
      mem_write(1'b1, 8'h90, 16'h9090);
      mem_read(8'h90, w);
      check("R11 write above bound blocked", 32'(w), 32'h0);
      mem_write(1'b1, 8'h10, 16'h1010);
      mem_read(8'h10, w);
      check("R11 write below bound lands", 32'(w), 32'h1010);
      mem_wrall(1'b1, 16'hFFFF);
      mem_read(8'h10, w);
      check("R10 write-all blocked while bound not FF", 32'(w), 32'h1010);
   endtask

   task automatic t_arm_consumed();
      logic [7:0] v, tail;
      logic dmy;
      pren_cmd();
      pr_read(v, dmy, tail);
      cmd(1'b1, 1'b1, 2'b11, 8'hFF);
      pr_read(v, dmy, tail);
      check("R11 arm lost after an intervening cycle", 32'(v), 32'h80);
   endtask

   task automatic t_wrall();
      logic [7:0] v, tail;
      logic dmy;
      logic [15:0] w;
      pren_cmd();
      cmd(1'b1, 1'b1, 2'b11, 8'hFF);
      pr_read(v, dmy, tail);
      check("R4 protect clear to FF", 32'(v), 32'hFF);
      mem_wrall(1'b1, 16'h5A5A);
      mem_read(8'hFF, w);
      check("R10 write-all reaches top word", 32'(w), 32'h5A5A);
      mem_read(8'h20, w);
      check("R10 write-all reaches word 20", 32'(w), 32'h5A5A);
   endtask

   task automatic t_invalid();
      logic q;
      logic [15:0] w;
      hdr(1'b0, 1'b1, 2'b11, 8'h30, 0, q);
      send16(16'h0000);
      end_cs();
      mem_read(8'h30, w);
      check("R3 opcode 11 with protect-select low does nothing", 32'(w), 32'h5A5A);
   endtask

   task automatic t_lock();
      logic [7:0] v, tail;
      logic dmy;
      logic [15:0] w;
      pren_cmd();
      cmd(1'b1, 1'b1, 2'b01, 8'h40);
      pren_cmd();
      cmd(1'b1, 1'b1, 2'b00, 8'h00);
      pren_cmd();
      cmd(1'b1, 1'b1, 2'b11, 8'hFF);
      pr_read(v, dmy, tail);
      check("R12 armed clear ignored after lock", 32'(v), 32'h40);
      mem_write(1'b1, 8'h50, 16'h0505);
      mem_read(8'h50, w);
      check("R12 locked bound still blocks", 32'(w), 32'h5A5A);
      mem_write(1'b1, 8'h30, 16'h0303);
      mem_read(8'h30, w);
      check("R12 write below locked bound lands", 32'(w), 32'h0303);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      t_reset();
      t_no_wen();
      t_enable_write();
      t_sequential();
      t_pe_low();
      t_abort();
      t_wds();
      t_prread_default();
      t_pren_needs_wen();
      t_protect_range();
      t_arm_consumed();
      t_wrall();
      t_invalid();
      t_lock();
      done = 1'b1;
      summary();
      $finish;
   end

endmodule